// File: doc/BRIEF.md
# Step-Commanded I2C Slave Byte Receiver

This block is the data-receive engine of an I2C slave in which software paces every bus step. Once the slave address and the direction bit have been matched by surrounding logic, the host writes a step code together with a one-cycle trigger. One code receives a single data byte. Two other codes return either an acknowledge or a not-acknowledge in the following bit slot. Between steps the engine holds SCL low, so the master waits until software is ready.

Both SCL and SDA pass through a two-flop synchroniser. Data bits are taken on each synchronised SCL rising edge and shifted in most significant bit first. The receive buffer is written only when the eighth bit has arrived. Each step reports completion through a busy flag, a status code and a one-cycle interrupt pulse. A stop condition is seen in every state. It abandons the current step and sets a status code of its own.

Top module: `i2c_rxs_top`

## Requirements
- R1: After reset, busy, irq, scl_low_o and sda_low_o are 0, status is 0 and rx_byte is 0x00.
- R2: A trigger with step code 3 sets busy one cycle later. Eight SCL rising edges then shift SDA in MSB first, and rx_byte is updated only when the eighth bit is taken.
- R3: When a byte completes, busy returns to 0, status becomes 3, and irq is high for exactly one cycle.
- R4: A trigger with step code 4 drives SDA low (sda_low_o = 1) until SCL falls after the acknowledge clock. Step code 5 leaves SDA released. At the end of either step, busy returns to 0, sda_low_o is 0, status becomes 4 and irq pulses for one cycle.
- R5: A stop condition (SDA rising while SCL is high) in any state aborts the step. Busy goes to 0 and status becomes 1. rx_byte keeps its value, and no irq is raised.
- R6: After a byte or an acknowledge step ends, scl_low_o is asserted once SCL is seen low. It stays asserted until the next accepted trigger or a stop, and it is never asserted while busy.
- R7: A trigger is ignored while busy is 1. A trigger carrying a step code other than 3, 4 or 5 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_code | input | 3 | Step selector: 3 = receive byte, 4 = ACK, 5 = NAK |
| step_go | input | 1 | One-cycle trigger that starts the selected step |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_low_o | output | 1 | 1 pulls SDA low (acknowledge) |
| rx_byte | output | 8 | Receive buffer holding the last complete byte |
| busy | output | 1 | A step is in progress |
| status | output | 3 | 0 none, 1 stop seen, 3 byte received, 4 ACK/NAK sent |
| irq | output | 1 | One-cycle pulse when a byte or an ACK/NAK step ends |

## Verification
The assertions check on every cycle that:
- busy rises only after a trigger;
- irq is a single-cycle pulse that coincides with busy falling;
- the buffer changes only together with a byte-complete interrupt;
- SDA is driven only during a busy step;
- SCL stretching never overlaps a busy step;
- a stop never raises an interrupt.

Only the bench scenarios can show the remaining behaviour. This covers the bit order and the captured byte values, the difference between ACK and NAK, the abandoning of a half-received byte on a stop, and the dropping of triggers that arrive while busy or carry an unused code.

// File: rtl/i2c_rxs_pkg.sv
package i2c_rxs_pkg;

    localparam int unsigned CODE_W = 3;
    localparam int unsigned STAT_W = 3;

    localparam logic [CODE_W-1:0] STEP_RECV = 3'd3;
    localparam logic [CODE_W-1:0] STEP_ACK  = 3'd4;
    localparam logic [CODE_W-1:0] STEP_NAK  = 3'd5;

    localparam logic [STAT_W-1:0] ST_NONE  = 3'd0;
    localparam logic [STAT_W-1:0] ST_STOP  = 3'd1;
    localparam logic [STAT_W-1:0] ST_BYTE  = 3'd3;
    localparam logic [STAT_W-1:0] ST_ACKED = 3'd4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RECV = 2'd1,
        PH_ACKS = 2'd2
    } phase_e;

endpackage

// File: rtl/i2c_rxs_sync.sv
module i2c_rxs_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '1;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_rxs_linemon.sv
module i2c_rxs_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic stop_seen
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;
    assign stop_seen = scl_s & prev_q.scl & sda_s & ~prev_q.sda;

endmodule

// File: rtl/i2c_rxs_ctrl.sv
module i2c_rxs_ctrl
    import i2c_rxs_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] step_code,
    input  logic              step_go,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              stop_seen,
    output logic              scl_low,
    output logic              sda_low,
    output logic [DATA_W-1:0] rx_byte,
    output logic              busy,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  shreg;
        logic [DATA_W-1:0]  rbuf;
        logic               busy;
        logic [STAT_W-1:0]  status;
        logic               irq;
        logic               pend;
        logic               hold;
        logic               drive;
        logic               seen_hi;
    } ctl_t;

    ctl_t s_d, s_q;

    logic code_ok;
    assign code_ok = (step_code == STEP_RECV) || (step_code == STEP_ACK) ||
                     (step_code == STEP_NAK);

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (stop_seen) begin
            s_d.phase   = PH_IDLE;
            s_d.busy    = 1'b0;
            s_d.status  = ST_STOP;
            s_d.pend    = 1'b0;
            s_d.hold    = 1'b0;
            s_d.drive   = 1'b0;
            s_d.cnt     = '0;
            s_d.seen_hi = 1'b0;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    if (step_go && code_ok) begin
                        s_d.busy    = 1'b1;
                        s_d.pend    = 1'b0;
                        s_d.hold    = 1'b0;
                        s_d.cnt     = '0;
                        s_d.seen_hi = 1'b0;
                        if (step_code == STEP_RECV) begin
                            s_d.phase = PH_RECV;
                        end else begin
                            s_d.phase = PH_ACKS;
                            s_d.drive = (step_code == STEP_ACK);
                        end
                    end else if (s_q.pend && !scl_s) begin
                        s_d.hold = 1'b1;
                        s_d.pend = 1'b0;
                    end
                end
                PH_RECV: begin
                    if (scl_rise) begin
                        s_d.shreg = {s_q.shreg[DATA_W-2:0], sda_s};
                        s_d.cnt   = s_q.cnt + 1'b1;
                        if (s_q.cnt == LAST_BIT) begin
                            s_d.rbuf   = {s_q.shreg[DATA_W-2:0], sda_s};
                            s_d.phase  = PH_IDLE;
                            s_d.busy   = 1'b0;
                            s_d.status = ST_BYTE;
                            s_d.irq    = 1'b1;
                            s_d.pend   = 1'b1;
                            s_d.cnt    = '0;
                        end
                    end
                end
                PH_ACKS: begin
                    if (scl_rise) begin
                        s_d.seen_hi = 1'b1;
                    end
                    if (scl_fall && s_q.seen_hi) begin
                        s_d.phase   = PH_IDLE;
                        s_d.busy    = 1'b0;
                        s_d.drive   = 1'b0;
                        s_d.status  = ST_ACKED;
                        s_d.irq     = 1'b1;
                        s_d.pend    = 1'b1;
                        s_d.seen_hi = 1'b0;
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, shreg: '0, rbuf: '0, busy: 1'b0,
                     status: ST_NONE, irq: 1'b0, pend: 1'b0, hold: 1'b0,
                     drive: 1'b0, seen_hi: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_low = s_q.hold;
    assign sda_low = s_q.drive;
    assign rx_byte = s_q.rbuf;
    assign busy    = s_q.busy;
    assign status  = s_q.status;
    assign irq     = s_q.irq;

endmodule

// File: rtl/i2c_rxs_top.sv
module i2c_rxs_top
    import i2c_rxs_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        step_code,
    input  logic              step_go,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output logic [DATA_W-1:0] rx_byte,
    output logic              busy,
    output logic [2:0]        status,
    output logic              irq
);

    logic [1:0] line_s;
    logic       scl_rise, scl_fall, stop_seen;

    i2c_rxs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (line_s)
    );

    i2c_rxs_linemon u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (line_s[1]),
        .sda_s    (line_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .stop_seen(stop_seen)
    );

    i2c_rxs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_code(step_code),
        .step_go  (step_go),
        .scl_s    (line_s[1]),
        .sda_s    (line_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .stop_seen(stop_seen),
        .scl_low  (scl_low_o),
        .sda_low  (sda_low_o),
        .rx_byte  (rx_byte),
        .busy     (busy),
        .status   (status),
        .irq      (irq)
    );

endmodule

// File: rtl/i2c_rxs_chk.sv
module i2c_rxs_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_go,
    input logic              scl_low_o,
    input logic              sda_low_o,
    input logic [DATA_W-1:0] rx_byte,
    input logic              busy,
    input logic [2:0]        status,
    input logic              irq
);

    // R2
    busy_from_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(step_go));

    // R2
    buf_only_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> (irq && status == 3'd3));

    // R3
    irq_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4
    sda_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low_o |-> busy);

    // R5
    stop_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(status) && status == 3'd1) |-> !irq);

    // R6
    stretch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_low_o |-> !busy);

endmodule

bind i2c_rxs_top i2c_rxs_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_i2c_rxs_top.sv
`timescale 1ns/1ps
module sim_i2c_rxs_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] step_code = 3'd0;
    logic       step_go = 1'b0;
    logic       scl_i = 1'b1;
    logic       sda_i = 1'b1;
    logic       scl_low_o, sda_low_o, busy, irq;
    logic [7:0] rx_byte;
    logic [2:0] status;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_rxs_top u0 (
        .clk(clk), .rst_n(rst_n), .step_code(step_code), .step_go(step_go),
        .scl_i(scl_i), .sda_i(sda_i), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
        .rx_byte(rx_byte), .busy(busy), .status(status), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: line history as queues, step progress as integers
    bit   hs[$];
    bit   hd[$];
    int   m_mode, m_bits, m_acc, m_buf, m_stat;
    bit   m_busy, m_irq, m_wait, m_str, m_drv, m_hi;

    always @(posedge clk) begin
        if (!rst_n) begin
            hs = '{1'b1, 1'b1, 1'b1};
            hd = '{1'b1, 1'b1, 1'b1};
            m_mode = 0; m_bits = 0; m_acc = 0; m_buf = 0; m_stat = 0;
            m_busy = 0; m_irq = 0; m_wait = 0; m_str = 0; m_drv = 0; m_hi = 0;
        end else begin
            bit c_now, c_old, d_now, d_old;
            c_now = hs[1]; c_old = hs[2];
            d_now = hd[1]; d_old = hd[2];
            m_irq = 0;
            if (c_now && c_old && d_now && !d_old) begin
                m_mode = 0; m_busy = 0; m_stat = 1; m_wait = 0; m_str = 0;
                m_drv = 0; m_bits = 0; m_hi = 0;
            end else if (m_mode == 0) begin
                if (step_go && step_code >= 3 && step_code <= 5) begin
                    m_busy = 1; m_wait = 0; m_str = 0; m_bits = 0; m_hi = 0;
                    if (step_code == 3) m_mode = 1;
                    else begin m_mode = 2; m_drv = (step_code == 4); end
                end else if (m_wait && !c_now) begin
                    m_str = 1; m_wait = 0;
                end
            end else if (m_mode == 1) begin
                if (c_now && !c_old) begin
                    m_acc = ((m_acc << 1) | int'(d_now)) & 8'hFF;
                    m_bits++;
                    if (m_bits == 8) begin
                        m_buf = m_acc; m_mode = 0; m_busy = 0; m_stat = 3;
                        m_irq = 1; m_wait = 1; m_bits = 0;
                    end
                end
            end else begin
                if (c_now && !c_old) m_hi = 1;
                else if (!c_now && c_old && m_hi) begin
                    m_mode = 0; m_busy = 0; m_drv = 0; m_stat = 4;
                    m_irq = 1; m_wait = 1; m_hi = 0;
                end
            end
            void'(hs.pop_back()); hs.push_front(scl_i);
            void'(hd.pop_back()); hd.push_front(sda_i);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 busy",     busy,      m_busy);
            check("R2 rx_byte",  rx_byte,   m_buf);
            check("R3 status",   status,    m_stat);
            check("R3 irq",      irq,       m_irq);
            check("R6 scl_low",  scl_low_o, m_str);
            check("R4 sda_low",  sda_low_o, m_drv);
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go(input logic [2:0] c);
        @(negedge clk);
        step_code = c; step_go = 1'b1;
        @(negedge clk);
        step_go = 1'b0;
    endtask

    task automatic clk_bit(input bit b);
        sda_i = b; ticks(4);
        scl_i = 1'b1; ticks(6);
        scl_i = 1'b0; ticks(4);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) clk_bit(v[i]);
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        // R1 reset values
        check("R1 busy", busy, 0);
        check("R1 status", status, 0);
        check("R1 rx_byte", rx_byte, 0);
        check("R1 scl_low", scl_low_o, 0);
        check("R1 sda_low", sda_low_o, 0);

        scl_i = 1'b0; ticks(4);
        go(3'd3);
        check("R2 busy set", busy, 1);
        send_byte(8'hA5);
        ticks(6);
        check("R2 byte A5", rx_byte, 8'hA5);
        check("R3 status byte", status, 3);
        check("R6 stretch after byte", scl_low_o, 1);

        go(3'd4);
        ticks(2);
        check("R4 ack drive", sda_low_o, 1);
        check("R6 stretch released", scl_low_o, 0);
        sda_i = 1'b1;
        scl_i = 1'b1; ticks(6); scl_i = 1'b0; ticks(6);
        check("R4 status ack", status, 4);
        check("R4 sda released", sda_low_o, 0);
        check("R6 stretch after ack", scl_low_o, 1);

        go(3'd3);
        go(3'd4);
        // R7 trigger while busy dropped: the byte still completes normally
        send_byte(8'h3C);
        ticks(6);
        check("R7 busy trigger ignored", rx_byte, 8'h3C);
        check("R7 no ack from dropped trigger", sda_low_o, 0);

        go(3'd5);
        ticks(2);
        check("R4 nak released", sda_low_o, 0);
        check("R4 nak busy", busy, 1);
        scl_i = 1'b1; ticks(6); scl_i = 1'b0; ticks(6);
        check("R4 nak status", status, 4);

        go(3'd6);
        ticks(3);
        check("R7 bad code ignored", busy, 0);
        check("R7 stretch kept", scl_low_o, 1);

        go(3'd3);
        clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
        sda_i = 1'b0; ticks(4);
        scl_i = 1'b1; ticks(6);
        sda_i = 1'b1; ticks(6);
        check("R5 stop status", status, 1);
        check("R5 stop busy", busy, 0);
        check("R5 buffer kept", rx_byte, 8'h3C);
        check("R6 no stretch after stop", scl_low_o, 0);
        ticks(10);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule